// File: doc/BRIEF.md
# Rotating Register Rename Unit

This unit turns architectural register numbers into physical register numbers for software-pipelined (modulo-scheduled) loops. Each of three register files (general, floating-point and predicate) has a rotating region. Inside that region an index is offset by a per-file rotation base, modulo the region size. Below the region, and above it, indices pass through unchanged. The register storage is not part of the unit. Only the index translation and the loop control that drives it are.

A loop-branch strobe checks a loop counter. If the counter is nonzero, the branch is taken: the counter decrements and all three rotation bases step down by one, modulo their region sizes. The effect is that a value written as rN in one iteration is read as rN+1 in the next. If the counter is zero, the branch falls through and nothing rotates.

The floating-point region (registers 32 to 127) and the predicate region (predicates 16 to 63) have fixed sizes. The general region starts at register 32 and has a programmable size. Each file has one read port and one write port, and every port translates combinationally.

Top module: `rot_rename`

## Requirements
- R1: After reset, every rotation base, the loop counter and the general size code are 0. Every port therefore maps identically, and `taken` is low while `loop_br` is low.
- R2: Indices below a file's rotating region map to themselves: general and floating-point below 32, predicate below 16. General indices at or above 32 plus the programmed size also map to themselves.
- R3: An index a inside a region of base B, size S and rotation base rrb maps to B + ((a − B + rrb) mod S). The read and write ports of a file use the same mapping. The floating-point region has B=32, S=96. The predicate region has B=16, S=48.
- R4: A loop branch with a nonzero counter drives `taken` high in the same cycle. At the next clock edge it decrements the counter by one and steps every rotation base to (rrb − 1) mod S. The new mapping is visible from the cycle after that edge.
- R5: A loop branch with a zero counter leaves `taken` low, leaves every mapping unchanged and leaves the counter at 0.
- R6: Rotation carries names forward. The physical index written as architectural rN before a taken branch equals the physical index read as rN+1 after it, whenever both lie inside the region.
- R7: `size_in` is a 4-bit code c, and the general region size is 8·c registers. A code of 0 disables general rotation, so every general index maps to itself while the other files still rotate. Codes above 12 are ignored and change no mapping.
- R8: An accepted size write clears all three rotation bases at the next edge. It takes precedence over a taken branch in the same cycle, although that branch still decrements the counter.
- R9: `cnt_we` loads `cnt_in` into the loop counter at the next edge. A load takes precedence over a decrement in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| size_we | input | 1 | Write strobe for the general region size code |
| size_in | input | 4 | General region size code, in units of 8 registers |
| cnt_we | input | 1 | Loop counter load strobe |
| cnt_in | input | CNT_W | Loop counter load value |
| loop_br | input | 1 | Loop-branch strobe |
| taken | output | 1 | Loop branch taken (counter was nonzero) |
| gr_rd_a | input | 7 | General read port, architectural index |
| gr_wr_a | input | 7 | General write port, architectural index |
| fr_rd_a | input | 7 | Floating-point read port, architectural index |
| fr_wr_a | input | 7 | Floating-point write port, architectural index |
| pr_rd_a | input | 6 | Predicate read port, architectural index |
| pr_wr_a | input | 6 | Predicate write port, architectural index |
| gr_rd_p | output | 7 | General read port, physical index |
| gr_wr_p | output | 7 | General write port, physical index |
| fr_rd_p | output | 7 | Floating-point read port, physical index |
| fr_wr_p | output | 7 | Floating-point write port, physical index |
| pr_rd_p | output | 6 | Predicate read port, physical index |
| pr_wr_p | output | 6 | Predicate write port, physical index |

## Verification
The translated indices and `taken` are combinational. The bench therefore changes addresses and strobes only after the falling edge and reads the outputs 1 ns later, within the same cycle. Branch, size and counter effects pass through one register, so the bench checks them from the falling edge that follows the rising edge that captured the strobe, never earlier. Each sweep compares every architectural index of all six ports with arithmetic computed from the bench's own copy of the rotation bases. That copy is updated only at those rising edges.

// File: rtl/rot_rename.sv
module rot_rename #(
  parameter int CNT_W    = 16,
  parameter int GR_BASE  = 32,
  parameter int GR_CMAX  = 12,
  parameter int FR_BASE  = 32,
  parameter int FR_SIZE  = 96,
  parameter int PR_BASE  = 16,
  parameter int PR_SIZE  = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             size_we,
  input  logic [3:0]       size_in,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             loop_br,
  output logic             taken,
  input  logic [6:0]       gr_rd_a,
  input  logic [6:0]       gr_wr_a,
  input  logic [6:0]       fr_rd_a,
  input  logic [6:0]       fr_wr_a,
  input  logic [5:0]       pr_rd_a,
  input  logic [5:0]       pr_wr_a,
  output logic [6:0]       gr_rd_p,
  output logic [6:0]       gr_wr_p,
  output logic [6:0]       fr_rd_p,
  output logic [6:0]       fr_wr_p,
  output logic [5:0]       pr_rd_p,
  output logic [5:0]       pr_wr_p
);

  localparam logic [6:0] GB = 7'(GR_BASE);
  localparam logic [6:0] FB = 7'(FR_BASE);
  localparam logic [6:0] FS = 7'(FR_SIZE);
  localparam logic [6:0] PB = 7'(PR_BASE);
  localparam logic [6:0] PS = 7'(PR_SIZE);

  logic [3:0]       gcode;
  logic [6:0]       g_rrb, f_rrb, p_rrb;
  logic [CNT_W-1:0] cnt;
  logic [6:0]       gsize;
  logic             rot, size_ok;

  assign gsize   = {gcode, 3'b000};
  assign rot     = loop_br && (cnt != '0);
  assign taken   = rot;
  assign size_ok = size_we && (size_in <= 4'(GR_CMAX));

  function automatic logic [6:0] remap(input logic [6:0] a, input logic [6:0] base,
                                       input logic [6:0] size, input logic [6:0] rrb);
    logic [7:0] off;
    if (size == '0 || a < base || {1'b0, a} >= {1'b0, base} + {1'b0, size})
      return a;
    off = {1'b0, a - base} + {1'b0, rrb};
    if (off >= {1'b0, size}) off = off - {1'b0, size};
    return base + off[6:0];
  endfunction

  function automatic logic [6:0] step(input logic [6:0] r, input logic [6:0] size);
    if (size == '0) return '0;
    return (r == '0) ? size - 7'd1 : r - 7'd1;
  endfunction

  logic [6:0] pr_rd_w, pr_wr_w;
  assign gr_rd_p = remap(gr_rd_a, GB, gsize, g_rrb);
  assign gr_wr_p = remap(gr_wr_a, GB, gsize, g_rrb);
  assign fr_rd_p = remap(fr_rd_a, FB, FS, f_rrb);
  assign fr_wr_p = remap(fr_wr_a, FB, FS, f_rrb);
  assign pr_rd_w = remap({1'b0, pr_rd_a}, PB, PS, p_rrb);
  assign pr_wr_w = remap({1'b0, pr_wr_a}, PB, PS, p_rrb);
  assign pr_rd_p = pr_rd_w[5:0];
  assign pr_wr_p = pr_wr_w[5:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcode <= '0;
      g_rrb <= '0;
      f_rrb <= '0;
      p_rrb <= '0;
      cnt   <= '0;
    end else begin
      if (size_ok) begin
        gcode <= size_in;
        g_rrb <= '0;
        f_rrb <= '0;
        p_rrb <= '0;
      end else if (rot) begin
        g_rrb <= step(g_rrb, gsize);
        f_rrb <= step(f_rrb, FS);
        p_rrb <= step(p_rrb, PS);
      end
      if (cnt_we)   cnt <= cnt_in;
      else if (rot) cnt <= cnt - 1'b1;
    end
  end

  assert_clear_on_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (size_we && size_in <= 4'(GR_CMAX)) |=> (g_rrb == '0 && f_rrb == '0 && p_rrb == '0));

  assert_fr_rotate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_br && cnt != '0 && !size_we) |=>
      (f_rrb == (($past(f_rrb) == '0) ? FS - 7'd1 : $past(f_rrb) - 7'd1)));

  assert_cnt_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_br && cnt != '0 && !cnt_we) |=> (cnt == $past(cnt) - 1'b1));

  assert_hold_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_br && cnt == '0 && !size_we && !cnt_we) |=>
      ($stable(f_rrb) && $stable(p_rrb) && $stable(g_rrb) && cnt == '0));

  assert_ignore_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (size_we && size_in > 4'(GR_CMAX) && !loop_br) |=> ($stable(gcode) && $stable(g_rrb)));

  assert_rrb_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (f_rrb < FS) && (p_rrb < PS) && (g_rrb < gsize || g_rrb == '0));

  always_comb begin
    if (rst_n && fr_rd_a < FB)
      assert_low_pass_R2: assert (fr_rd_p == fr_rd_a);
  end

endmodule

// File: tb/test_rot_rename.sv
`timescale 1ns/1ps
module test_rot_rename;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        size_we = 1'b0;
  logic [3:0]  size_in = '0;
  logic        cnt_we = 1'b0;
  logic [15:0] cnt_in = '0;
  logic        loop_br = 1'b0;
  logic        taken;
  logic [6:0]  gr_rd_a = '0, gr_wr_a = '0, fr_rd_a = '0, fr_wr_a = '0;
  logic [5:0]  pr_rd_a = '0, pr_wr_a = '0;
  logic [6:0]  gr_rd_p, gr_wr_p, fr_rd_p, fr_wr_p;
  logic [5:0]  pr_rd_p, pr_wr_p;

  int checks = 0, errors = 0;
  int g_rrb = 0, f_rrb = 0, p_rrb = 0, gsz = 0, cnt = 0;

  always #4 clk = ~clk;

  rot_rename i_rot_rename (
    .clk(clk), .rst_n(rst_n), .size_we(size_we), .size_in(size_in),
    .cnt_we(cnt_we), .cnt_in(cnt_in), .loop_br(loop_br), .taken(taken),
    .gr_rd_a(gr_rd_a), .gr_wr_a(gr_wr_a), .fr_rd_a(fr_rd_a), .fr_wr_a(fr_wr_a),
    .pr_rd_a(pr_rd_a), .pr_wr_a(pr_wr_a), .gr_rd_p(gr_rd_p), .gr_wr_p(gr_wr_p),
    .fr_rd_p(fr_rd_p), .fr_wr_p(fr_wr_p), .pr_rd_p(pr_rd_p), .pr_wr_p(pr_wr_p));

  function automatic int emap(int a, int base, int size, int rrb);
    if (size == 0 || a < base || a >= base + size) return a;
    return base + (a - base + rrb) % size;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sweep(string req);
    for (int a = 0; a < 128; a++) begin
      gr_rd_a = 7'(a); gr_wr_a = 7'(127 - a);
      fr_rd_a = 7'(a); fr_wr_a = 7'(127 - a);
      pr_rd_a = 6'(a % 64); pr_wr_a = 6'(63 - a % 64);
      #0.05;
      chk(req, gr_rd_p, emap(a, 32, gsz, g_rrb));
      chk(req, gr_wr_p, emap(127 - a, 32, gsz, g_rrb));
      chk(req, fr_rd_p, emap(a, 32, 96, f_rrb));
      chk(req, fr_wr_p, emap(127 - a, 32, 96, f_rrb));
      chk(req, pr_rd_p, emap(a % 64, 16, 48, p_rrb));
      chk(req, pr_wr_p, emap(63 - a % 64, 16, 48, p_rrb));
    end
  endtask

  task automatic model_rot();
    if (gsz > 0) g_rrb = (g_rrb + gsz - 1) % gsz;
    f_rrb = (f_rrb + 95) % 96;
    p_rrb = (p_rrb + 47) % 48;
  endtask

  // one branch; taken is sampled in the strobe cycle, state updated at the edge
  task automatic branch(string req);
    @(negedge clk);
    loop_br = 1'b1;
    #1;
    chk(req, taken, cnt != 0);
    @(posedge clk);
    if (cnt != 0) begin cnt--; model_rot(); end
    @(negedge clk);
    loop_br = 1'b0;
  endtask

  task automatic write_size(int code);
    @(negedge clk);
    size_we = 1'b1; size_in = 4'(code);
    @(posedge clk);
    if (code <= 12) begin gsz = code * 8; g_rrb = 0; f_rrb = 0; p_rrb = 0; end
    @(negedge clk);
    size_we = 1'b0;
  endtask

  task automatic load_cnt(int v);
    @(negedge clk);
    cnt_we = 1'b1; cnt_in = 16'(v);
    @(posedge clk);
    cnt = v;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w32;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: identity after reset, taken low
    chk("R1", taken, 0);
    sweep("R1");
    // R5: branch with zero count after reset does nothing
    branch("R5");
    #1; sweep("R5");

    // R3/R4/R2: 16-register general region, five iterations then fall-through
    write_size(2);
    load_cnt(5);
    for (int i = 0; i < 7; i++) begin
      gr_wr_a = 7'd32; fr_wr_a = 7'd40; #0.1;
      w32 = gr_wr_p;
      branch(i < 5 ? "R4" : "R5");
      #1;
      if (i < 5) begin
        gr_rd_a = 7'd33; #0.1;
        chk("R6", gr_rd_p, w32);
      end
      sweep("R3");
    end
    chk("R5", cnt, 0);

    // R7: size code 0 disables general rotation only
    write_size(0);
    load_cnt(3);
    for (int i = 0; i < 3; i++) begin branch("R4"); #1; sweep("R7"); end
    // R7: out-of-range code ignored, mappings kept
    load_cnt(2);
    write_size(12);
    branch("R4"); branch("R4");
    write_size(13);
    #1; sweep("R7");
    write_size(15);
    #1; sweep("R7");

    // R8: size write wins over a same-cycle taken branch; counter still drops
    load_cnt(4);
    branch("R4");
    @(negedge clk);
    size_we = 1'b1; size_in = 4'd3; loop_br = 1'b1;
    #1; chk("R8", taken, 1);
    @(posedge clk);
    gsz = 24; g_rrb = 0; f_rrb = 0; p_rrb = 0; cnt--;
    @(negedge clk);
    size_we = 1'b0; loop_br = 1'b0;
    #1; sweep("R8");

    // R9: load wins over decrement; exactly 2 taken branches follow
    @(negedge clk);
    cnt_we = 1'b1; cnt_in = 16'd2; loop_br = 1'b1;
    @(posedge clk);
    model_rot(); cnt = 2;
    @(negedge clk);
    cnt_we = 1'b0; loop_br = 1'b0;
    branch("R9"); branch("R9"); branch("R9");
    chk("R9", cnt, 0);
    #1; sweep("R9");

    // R4/R6: full 96-register general region with more rotations than the region holds
    write_size(12);
    load_cnt(100);
    for (int i = 0; i < 100; i++) begin
      gr_wr_a = 7'd50; fr_wr_a = 7'd127; #0.1;
      w32 = fr_wr_p;
      branch("R4");
      if (i % 10 == 9) begin #1; sweep("R4"); end
    end
    #1; sweep("R3");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule